// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block is a single transmit DMA channel. Software places a chain of four-word buffer descriptors in a shared memory and writes the address of the first one into the channel's head register. The engine then works through the chain without further help. For each descriptor it reads the descriptor words, streams the referenced buffer out one byte per beat on a valid/ready output that marks the first and last byte, and writes the mode word back with the ownership flag cleared. It then moves on to the next pointer.

When the engine reaches a descriptor whose next pointer is zero, it also sets the end-of-queue flag in that mode word, clears the head register and goes idle. To continue, software links a new descriptor after the old tail and writes the new descriptor's address into the head register. A completion register holds the address of the last descriptor that software has acknowledged. A control register holds the channel enable and a self-clearing soft reset.

The memory port has a single access per cycle. Reads return data one cycle after the request. A write takes effect in the cycle it is issued.

Top module: `txdesc_dma`

## Requirements
- R1: A descriptor at address A holds its next pointer at A+0, its buffer pointer at A+4, a buffer-length word at A+8 that the engine does not use, and its mode word at A+12. In the mode word, bit 31 is start-of-packet, bit 30 is end-of-packet, bit 29 is ownership (1 = engine owns it) and bit 28 is end-of-queue. Bits 10:0 give the number of bytes to send. The low two bits of the buffer pointer are ignored.
- R2: Writing a nonzero address to the head register (reg_sel=1) while the channel is idle and enabled starts processing at that descriptor. The buffer bytes leave least-significant byte of each memory word first. tx_sop marks byte 0 and tx_eop marks byte length-1.
- R3: While tx_valid is high and tx_ready is low, tx_data, tx_sop and tx_eop hold their values.
- R4: After the last byte of a descriptor is accepted, the engine writes the mode word back with bit 29 cleared and all other bits kept. If the next pointer is zero, it also sets bit 28, and head_o becomes zero.
- R5: A nonzero next pointer makes the engine continue with that descriptor without any software action.
- R6: A descriptor whose ownership bit is already clear when it is fetched ends the chain. No byte is sent, no write-back occurs, head_o becomes zero, and descriptors linked after it are not touched.
- R7: Once the engine has stopped at end of queue, a descriptor appended to the old tail is not processed until software writes its address to the head register.
- R8: A head-register write is ignored while a descriptor is being fetched or streamed. In the write-back cycle of a descriptor whose next pointer is zero, the written value replaces the zero and processing continues there.
- R9: A write with reg_sel=2 stores the data on cmpl_o. The engine itself never changes cmpl_o.
- R10: Bit 0 of the control register (reg_sel=0) is the enable, and descriptors are fetched only while it is 1. Clearing it during a packet lets that descriptor finish. head_o then holds its next pointer until the enable is set again, and processing resumes from there.
- R11: Writing bit 1 of the control register raises srst_o for exactly one cycle. On the following cycle the stream has stopped, no write-back has taken place, and head_o and cmpl_o are zero. The enable is preserved.
- R12: A descriptor whose length field is zero sends no byte but is still written back as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 head, 2 completion |
| reg_wdata | input | 32 | Register write data |
| en_o | output | 1 | Current channel enable |
| srst_o | output | 1 | Soft reset pending |
| head_o | output | 32 | Head descriptor pointer |
| cmpl_o | output | 32 | Completion pointer |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Byte address of a 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The sharpest collision is between the engine's own head update at the end of a chain and a software head write. Both can land in the final write-back cycle, where the engine wants to clear the register and software wants to restart it. The bench watches the memory port for the write-back strobe and issues the head write in that same cycle. It then expects the second descriptor to be streamed and written back, rather than the restart being lost. A soft reset arriving while a byte is stalled on the stream is also forced. In that case the check is that the byte is dropped without any write-back.

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
  parameter int LEN_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic        en_o,
  output logic        srst_o,
  output logic [31:0] head_o,
  output logic [31:0] cmpl_o,
  output logic        mem_en,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_sop,
  output logic        tx_eop,
  input  logic        tx_ready
);
  localparam int OWN_B = 29;
  localparam int EOQ_B = 28;

  typedef enum logic [2:0] {
    S_IDLE, S_FMODE, S_FNEXT, S_FBUF, S_WREQ, S_WCAP, S_SEND, S_WB
  } st_t;

  st_t              st_q;
  logic             en_q, srst_q;
  logic [31:0]      head_q, cmpl_q, mode_q, next_q, word_q;
  logic [31:2]      buf_q;
  logic [LEN_W-1:0] bcnt_q;

  logic [LEN_W-1:0] plen, boff;
  logic             head_wr, launch, last, take;
  logic [31:0]      wb_mode;

  assign plen    = mode_q[LEN_W-1:0];
  assign boff    = {bcnt_q[LEN_W-1:2], 2'b00};
  assign last    = (bcnt_q == plen - LEN_W'(1));
  assign head_wr = reg_we && (reg_sel == 2'd1);
  assign launch  = (st_q == S_IDLE) && en_q && !srst_q && (head_q != 32'd0) && !head_wr;
  assign take    = tx_valid && tx_ready;
  assign wb_mode = (mode_q & ~(32'd1 << OWN_B)) | ((next_q == 32'd0) ? (32'd1 << EOQ_B) : 32'd0);

  assign en_o     = en_q;
  assign srst_o   = srst_q;
  assign head_o   = head_q;
  assign cmpl_o   = cmpl_q;
  assign tx_valid = (st_q == S_SEND);
  assign tx_data  = word_q[{bcnt_q[1:0], 3'b000} +: 8];
  assign tx_sop   = tx_valid && (bcnt_q == '0);
  assign tx_eop   = tx_valid && last;
  assign mem_we   = (st_q == S_WB);
  assign mem_wdata = wb_mode;

  always_comb begin
    mem_en   = 1'b0;
    mem_addr = head_q + 32'd12;
    case (st_q)
      S_IDLE:  mem_en = launch;
      S_FMODE: begin mem_en = mem_rdata[OWN_B]; mem_addr = head_q; end
      S_FNEXT: begin mem_en = 1'b1; mem_addr = head_q + 32'd4; end
      S_WREQ:  begin mem_en = 1'b1; mem_addr = {buf_q, 2'b00} + 32'(boff); end
      S_WB:    mem_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      head_q <= '0;
      cmpl_q <= '0;
      mode_q <= '0;
      next_q <= '0;
      word_q <= '0;
      buf_q  <= '0;
      bcnt_q <= '0;
    end else if (srst_q) begin
      st_q   <= S_IDLE;
      srst_q <= 1'b0;
      head_q <= '0;
      cmpl_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (reg_we && reg_sel == 2'd0) begin
        en_q <= reg_wdata[0];
        if (reg_wdata[1]) srst_q <= 1'b1;
      end
      if (reg_we && reg_sel == 2'd2) cmpl_q <= reg_wdata;
      case (st_q)
        S_IDLE: begin
          if (head_wr) head_q <= reg_wdata;
          else if (launch) st_q <= S_FMODE;
        end
        S_FMODE: begin
          mode_q <= mem_rdata;
          if (mem_rdata[OWN_B]) st_q <= S_FNEXT;
          else begin
            head_q <= '0;
            st_q   <= S_IDLE;
          end
        end
        S_FNEXT: begin
          next_q <= mem_rdata;
          st_q   <= S_FBUF;
        end
        S_FBUF: begin
          buf_q  <= mem_rdata[31:2];
          bcnt_q <= '0;
          st_q   <= (plen == '0) ? S_WB : S_WREQ;
        end
        S_WREQ: st_q <= S_WCAP;
        S_WCAP: begin
          word_q <= mem_rdata;
          st_q   <= S_SEND;
        end
        S_SEND: begin
          if (take) begin
            if (last) st_q <= S_WB;
            else begin
              bcnt_q <= bcnt_q + LEN_W'(1);
              if (bcnt_q[1:0] == 2'd3) st_q <= S_WREQ;
            end
          end
        end
        S_WB: begin
          head_q <= (head_wr && next_q == 32'd0) ? reg_wdata : next_q;
          st_q   <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic        mem_en,
  input logic        mem_we,
  input logic        wb_own,
  input logic        wb_eoq,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        tx_ready,
  input logic        srst_o,
  input logic [31:0] head_o,
  input logic [31:0] cmpl_o
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !srst_o |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  p_wb_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |-> !wb_own);

  p_eoq_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && wb_eoq && !(reg_we && reg_sel == 2'd1) |=> head_o == 32'd0);

  p_nomem_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !mem_en);

  p_cmpl_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_sel == 2'd2) && !srst_o |=> $stable(cmpl_o));

  p_srst_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |=> !srst_o && !tx_valid && head_o == 32'd0 && cmpl_o == 32'd0);
endmodule

bind txdesc_dma txdesc_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
  .mem_en(mem_en), .mem_we(mem_we), .wb_own(mem_wdata[29]), .wb_eoq(mem_wdata[28]),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
  .tx_ready(tx_ready), .srst_o(srst_o), .head_o(head_o), .cmpl_o(cmpl_o)
);

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SOPM = 32'h8000_0000;
  localparam logic [31:0] EOPM = 32'h4000_0000;
  localparam logic [31:0] OWNM = 32'h2000_0000;
  localparam logic [31:0] EOQM = 32'h1000_0000;
  localparam logic [31:0] D0 = 32'h100, D1 = 32'h110, D2 = 32'h120, D3 = 32'h130, D4 = 32'h140;
  localparam logic [31:0] B0 = 32'h200, B1 = 32'h240, B2 = 32'h280, B3 = 32'h300, B4 = 32'h340;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic en_o, srst_o, mem_en, mem_we, tx_valid, tx_sop, tx_eop;
  logic tx_ready = 1'b0;
  logic [31:0] head_o, cmpl_o, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic [7:0] tx_data;

  logic [31:0] mem [0:255];
  int n_checks = 0, n_errs = 0, mon_checks = 0, mon_errs = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [7:0] rx_b [0:2047];
  logic rx_s [0:2047];
  logic rx_e [0:2047];
  int rx_n = 0;
  logic [7:0] exp_b [0:2047];
  logic exp_s [0:2047];
  logic exp_e [0:2047];
  int exp_n = 0, st_base = 0;
  logic pv = 1'b0, pr = 1'b0, psr = 1'b0, ps = 1'b0, pe = 1'b0;
  logic [7:0] pd = 8'd0;

  txdesc_dma u_txdesc_dma (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .en_o(en_o), .srst_o(srst_o), .head_o(head_o), .cmpl_o(cmpl_o),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_sop(tx_sop),
    .tx_eop(tx_eop), .tx_ready(tx_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      else mem_rdata <= mem[mem_addr[9:2]];
    end
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready <= (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (pv && !pr && !psr) begin
        mon_checks++;
        if (!(tx_valid && tx_data == pd && tx_sop == ps && tx_eop == pe)) begin
          mon_errs++;
          $display("FAIL R3 stalled byte changed actual=%h expected=%h", tx_data, pd);
        end
      end
      if (tx_valid && tx_ready) begin
        rx_b[rx_n] = tx_data; rx_s[rx_n] = tx_sop; rx_e[rx_n] = tx_eop;
        rx_n++;
      end
    end
    pv = tx_valid; pr = tx_ready; psr = srst_o; pd = tx_data; ps = tx_sop; pe = tx_eop;
  end

  task automatic check_eq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] bp,
                          input int len, input bit own);
    mem[a[9:2]]       = nxt;
    mem[a[9:2] + 8'd1] = bp;
    mem[a[9:2] + 8'd2] = 32'(len + 100);
    mem[a[9:2] + 8'd3] = SOPM | EOPM | (own ? OWNM : 32'd0) | 32'(len);
  endtask

  task automatic load_pkt(input logic [31:0] bp, input int len, input int seed);
    for (int k = 0; k < len; k++) begin
      logic [7:0] v;
      v = 8'(seed + k * 7);
      mem[bp[9:2] + 8'(k / 4)][8 * (k % 4) +: 8] = v;
      exp_b[exp_n] = v; exp_s[exp_n] = (k == 0); exp_e[exp_n] = (k == len - 1);
      exp_n++;
    end
  endtask

  task automatic begin_test();
    st_base = rx_n;
    exp_n = rx_n;
  endtask

  task automatic wait_quiet();
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (head_o == 32'd0 && !tx_valid && !mem_en) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_valid();
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (tx_valid) break;
    end
  endtask

  task automatic check_stream(input string req);
    int bad;
    bad = 0;
    check_eq(req, "byte count", 32'(rx_n), 32'(exp_n));
    for (int i = st_base; i < exp_n && i < rx_n; i++)
      if (rx_b[i] !== exp_b[i] || rx_s[i] !== exp_s[i] || rx_e[i] !== exp_e[i]) bad++;
    check_eq(req, "bytes or markers mismatched", 32'(bad), 32'd0);
  endtask

  function automatic logic [31:0] mode_of(input logic [31:0] a);
    return mem[a[9:2] + 8'd3];
  endfunction

  task automatic t_reset();
    check_eq("R2", "reset tx_valid", {31'd0, tx_valid}, 32'd0);
    check_eq("R2", "reset head", head_o, 32'd0);
    check_eq("R9", "reset completion", cmpl_o, 32'd0);
    check_eq("R10", "reset enable", {31'd0, en_o}, 32'd0);
    check_eq("R11", "reset srst", {31'd0, srst_o}, 32'd0);
  endtask

  task automatic t_single();
    begin_test();
    put_desc(D0, 0, B0 | 32'd2, 7, 1'b1);
    load_pkt(B0, 7, 3);
    wr_reg(2'd1, D0);
    wait_quiet();
    check_stream("R2");
    check_eq("R1", "length from mode word, aligned buffer", 32'(rx_n - st_base), 32'd7);
    check_eq("R4", "written-back mode", mode_of(D0), SOPM | EOPM | EOQM | 32'd7);
    check_eq("R4", "head after end of queue", head_o, 32'd0);
  endtask

  task automatic t_chain();
    begin_test();
    rdy_mode = 1;
    put_desc(D0, D1, B0, 5, 1'b1); load_pkt(B0, 5, 20);
    put_desc(D1, D2, B1, 8, 1'b1); load_pkt(B1, 8, 40);
    put_desc(D2, 0, B2, 1, 1'b1);  load_pkt(B2, 1, 60);
    wr_reg(2'd1, D0);
    wait_quiet();
    rdy_mode = 0;
    check_stream("R5");
    check_eq("R5", "first mode", mode_of(D0), SOPM | EOPM | 32'd5);
    check_eq("R5", "second mode", mode_of(D1), SOPM | EOPM | 32'd8);
    check_eq("R4", "tail mode", mode_of(D2), SOPM | EOPM | EOQM | 32'd1);
  endtask

  task automatic t_owner();
    begin_test();
    put_desc(D3, D4, B3, 4, 1'b0);
    put_desc(D4, 0, B4, 3, 1'b1);
    wr_reg(2'd1, D3);
    wait_quiet();
    check_eq("R6", "bytes sent", 32'(rx_n - st_base), 32'd0);
    check_eq("R6", "unowned mode untouched", mode_of(D3), SOPM | EOPM | 32'd4);
    check_eq("R6", "follower untouched", mode_of(D4), SOPM | EOPM | OWNM | 32'd3);
    check_eq("R6", "head cleared", head_o, 32'd0);
  endtask

  task automatic t_restart();
    begin_test();
    put_desc(D0, 0, B0, 6, 1'b1); load_pkt(B0, 6, 77);
    wr_reg(2'd1, D0);
    wait_quiet();
    check_stream("R7");
    begin_test();
    put_desc(D1, 0, B1, 9, 1'b1);
    mem[D0[9:2]] = D1;
    repeat (30) @(negedge clk);
    check_eq("R7", "no progress before restart", 32'(rx_n - st_base), 32'd0);
    check_eq("R7", "appended still owned", mode_of(D1), SOPM | EOPM | OWNM | 32'd9);
    load_pkt(B1, 9, 91);
    wr_reg(2'd1, D1);
    wait_quiet();
    check_stream("R7");
    check_eq("R7", "appended written back", mode_of(D1), SOPM | EOPM | EOQM | 32'd9);
  endtask

  task automatic t_inflight();
    begin_test();
    rdy_mode = 2;
    put_desc(D0, 0, B0, 12, 1'b1); load_pkt(B0, 12, 5);
    put_desc(D1, 0, B1, 3, 1'b1);
    wr_reg(2'd1, D0);
    wait_valid();
    wr_reg(2'd1, D1);
    check_eq("R8", "head write ignored in flight", head_o, D0);
    rdy_mode = 0;
    wait_quiet();
    check_stream("R8");
    check_eq("R8", "ignored target untouched", mode_of(D1), SOPM | EOPM | OWNM | 32'd3);
    begin_test();
    put_desc(D2, 0, B2, 5, 1'b1); load_pkt(B2, 5, 100);
    put_desc(D3, 0, B3, 4, 1'b1); load_pkt(B3, 4, 130);
    wr_reg(2'd1, D2);
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (mem_en && mem_we) break;
    end
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = D3;
    @(negedge clk);
    reg_we = 1'b0;
    wait_quiet();
    check_stream("R8");
    check_eq("R8", "restart in write-back cycle", mode_of(D3), SOPM | EOPM | EOQM | 32'd4);
  endtask

  task automatic t_cmpl();
    begin_test();
    wr_reg(2'd2, D0);
    check_eq("R9", "completion stored", cmpl_o, D0);
    put_desc(D4, 0, B4, 2, 1'b1); load_pkt(B4, 2, 9);
    wr_reg(2'd1, D4);
    wait_quiet();
    check_stream("R9");
    check_eq("R9", "completion kept by engine", cmpl_o, D0);
  endtask

  task automatic t_enable();
    begin_test();
    rdy_mode = 2;
    put_desc(D0, D1, B0, 6, 1'b1); load_pkt(B0, 6, 33);
    put_desc(D1, 0, B1, 4, 1'b1);
    wr_reg(2'd1, D0);
    wait_valid();
    wr_reg(2'd0, 32'd0);
    rdy_mode = 0;
    repeat (60) @(negedge clk);
    check_eq("R10", "enable off", {31'd0, en_o}, 32'd0);
    check_stream("R10");
    check_eq("R10", "head holds next", head_o, D1);
    check_eq("R10", "next not fetched", mode_of(D1), SOPM | EOPM | OWNM | 32'd4);
    load_pkt(B1, 4, 51);
    wr_reg(2'd0, 32'd1);
    wait_quiet();
    check_stream("R10");
  endtask

  task automatic t_srst();
    begin_test();
    wr_reg(2'd2, 32'h55);
    rdy_mode = 2;
    put_desc(D0, 0, B0, 10, 1'b1);
    wr_reg(2'd1, D0);
    wait_valid();
    wr_reg(2'd0, 32'd3);
    check_eq("R11", "srst raised", {31'd0, srst_o}, 32'd1);
    @(negedge clk);
    check_eq("R11", "srst self-cleared", {31'd0, srst_o}, 32'd0);
    check_eq("R11", "stream stopped", {31'd0, tx_valid}, 32'd0);
    check_eq("R11", "head cleared", head_o, 32'd0);
    check_eq("R11", "completion cleared", cmpl_o, 32'd0);
    check_eq("R11", "enable kept", {31'd0, en_o}, 32'd1);
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    check_eq("R11", "no bytes", 32'(rx_n - st_base), 32'd0);
    check_eq("R11", "no write-back", mode_of(D0), SOPM | EOPM | OWNM | 32'd10);
  endtask

  task automatic t_zero();
    begin_test();
    put_desc(D2, 0, B2, 0, 1'b1);
    wr_reg(2'd1, D2);
    wait_quiet();
    check_eq("R12", "no bytes", 32'(rx_n - st_base), 32'd0);
    check_eq("R12", "written back", mode_of(D2), SOPM | EOPM | EOQM);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr_reg(2'd0, 32'd1);
    t_single();
    t_chain();
    t_owner();
    t_restart();
    t_inflight();
    t_cmpl();
    t_enable();
    t_srst();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", n_checks + mon_checks, n_errs + mon_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks + mon_checks + 1, n_errs + mon_errs);
    $finish;
  end
endmodule